// File: doc/BRIEF.md
# I2C Register-Pointer Slave Interface

This block is the serial front end of a small sensor register map. It watches SCL and SDA, decodes START, STOP and repeated START, and answers a 7-bit device address built from a fixed 4-bit prefix (`1001`) and three strap inputs. A persistent 2-bit pointer, loaded by the first byte after a write address, selects one of four 16-bit registers. The pointer is presented on `reg_sel`. Data bytes that follow the pointer byte come out on a one-cycle write strobe. Reads return the selected register most significant byte first.

The register storage itself sits outside the block. The block drives `reg_sel` and reads `rd_data`. It pulses `rd_done` when a full two-byte read has finished, so that an alert block can clear its interrupt-mode latch. The block also handles the general-call latch and reset commands, the alert-response read and the high-speed master code.

SCL and SDA are sampled by the system clock. Each data bit must therefore hold SCL low and SCL high for several system clock cycles.

Top module: `i2cp_slave`

## Requirements
- R1: A START condition (SDA falls while SCL is high) begins address reception from any state, including in the middle of a byte. A STOP condition (SDA rises while SCL is high) returns the block to idle with SDA released.
- R2: An address byte whose upper seven bits equal `{4'b1001, latched straps}` is acknowledged by driving SDA low during the ninth clock. Any other non-special address is not acknowledged and the rest of the transfer is ignored.
- R3: The strap inputs are captured only while reset is asserted and on a general-call latch or reset command. A change of strap at any other time does not change the address the block answers.
- R4: In a write, the first byte after the address sets the pointer to its two low bits, and the pointer appears on `reg_sel`. The pointer is 00 after reset and keeps its value across transfers. A write carrying only the pointer byte is legal.
- R5: Data bytes after the pointer byte are acknowledged. The first is issued with `wr_lsb`=0 (upper byte) and the second with `wr_lsb`=1 (lower byte). Any later byte is acknowledged but is not written.
- R6: No write strobe is ever issued while the pointer is 00 (temperature). While the pointer is 01 (configuration), only the first data byte is written.
- R7: A read returns `rd_data[15:8]`, then `rd_data[7:0]`, for the current pointer. A master NACK ends the transfer. Any byte read after the second one reads as 8'hFF.
- R8: `rd_done` is a one-cycle pulse after the ninth clock of the second byte of a read. It does not pulse when the master NACKs the first byte.
- R9: General call (first byte 8'h00) is acknowledged. A second byte of 8'h04 re-latches the straps. A second byte of 8'h06 re-latches the straps, pulses `gc_reset` and returns the pointer to 00.
- R10: A first byte matching `00001xxx` is not acknowledged. It sets `hs_mode`, which stays set across repeated STARTs and clears only at STOP.
- R11: The alert-response read (first byte 8'h19) is acknowledged only while `alert_pending` is high. The block then sends `{own 7-bit address, alert_cause}`, where cause 1 means high limit and 0 means low limit.
- R12: If SDA reads low while the block is releasing it during the alert-response byte, the block stops driving and `alert_clear` does not pulse. If the byte completes, `alert_clear` pulses once.
- R13: The block starts pulling SDA low only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| strap | input | 3 | Low address bits from strap pins |
| reg_sel | output | 2 | Current pointer, selects the register for reads and writes |
| rd_data | input | 16 | Contents of the selected register |
| rd_done | output | 1 | One-cycle pulse after a complete two-byte read |
| wr_en | output | 1 | One-cycle write strobe |
| wr_lsb | output | 1 | 0: upper byte, 1: lower byte |
| wr_data | output | 8 | Byte to be written |
| alert_pending | input | 1 | An alert is waiting to be reported |
| alert_cause | input | 1 | 1 high limit, 0 low limit |
| alert_clear | output | 1 | One-cycle pulse when the alert response was delivered |
| gc_reset | output | 1 | One-cycle pulse on a general-call reset |
| hs_mode | output | 1 | High-speed master code seen, cleared by STOP |

## Verification
The assertions take for granted that SCL and SDA never change in the same sampled cycle. They also assume that every SCL phase lasts longer than the synchronizer depth, and that `alert_pending` stays high from the acknowledge of an alert-response address until that transfer ends. The bench master changes SDA only in the middle of the SCL low phase and holds each quarter bit for eight clock cycles. It keeps `alert_pending` constant across each whole transfer, and it pulls SDA low only when it plays the competing device during arbitration.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_BYTES = 2;
  localparam int REG_W    = BYTE_W * REG_BYTES;
  localparam int BITCNT_W = 4;
  localparam logic [7:0] GC_ADDR   = 8'h00;
  localparam logic [7:0] ARA_RD    = 8'h19;
  localparam logic [7:0] GC_LATCH  = 8'h04;
  localparam logic [7:0] GC_RESET  = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_RDATA, ST_GCCMD, ST_ARA, ST_SKIP
  } eng_st_t;

  function automatic logic is_hs_code(input logic [7:0] b);
    return b[7:3] == 5'b00001;
  endfunction

  function automatic logic [7:0] ara_reply(input logic [6:0] a, input logic cause);
    return {a, cause};
  endfunction

  function automatic logic keeps_byte(input logic [1:0] ptr, input logic [1:0] idx);
    return (ptr != 2'b00) && (idx < 2'd2) && !(ptr == 2'b01 && idx != 2'd0);
  endfunction
endpackage

// File: rtl/i2cp_bus_cond.sv
module i2cp_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

  // R1
  bus_evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));
endmodule

// File: rtl/i2cp_addr_dec.sv
module i2cp_addr_dec import i2cp_pkg::*; #(
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] PREFIX = 4'b1001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               relatch,
  input  logic [7:0]         rx_byte,
  output logic [6:0]         own_addr,
  output logic               hit_w,
  output logic               hit_r,
  output logic               hit_gc,
  output logic               hit_ara,
  output logic               hit_hs
);
  logic [STRAP_W-1:0] strap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       strap_q <= strap;
    else if (relatch) strap_q <= strap;
  end

  assign own_addr = {PREFIX, strap_q};
  assign hit_w    = rx_byte == {own_addr, 1'b0};
  assign hit_r    = rx_byte == {own_addr, 1'b1};
  assign hit_gc   = rx_byte == GC_ADDR;
  assign hit_ara  = rx_byte == ARA_RD;
  assign hit_hs   = is_hs_code(rx_byte);

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !relatch |=> $stable(own_addr));
endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine import i2cp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [6:0]       own_addr,
  input  logic             hit_w,
  input  logic             hit_r,
  input  logic             hit_gc,
  input  logic             hit_ara,
  input  logic             hit_hs,
  input  logic [REG_W-1:0] rd_data,
  input  logic             alert_pending,
  input  logic             alert_cause,
  output logic [7:0]       rx_byte,
  output logic             sda_oe,
  output logic [1:0]       reg_sel,
  output logic             rd_done,
  output logic             wr_en,
  output logic             wr_lsb,
  output logic [7:0]       wr_data,
  output logic             alert_clear,
  output logic             gc_reset,
  output logic             relatch,
  output logic             hs_mode
);
  eng_st_t st;
  logic [BITCNT_W-1:0] bitcnt;
  logic [7:0] shreg, txreg;
  logic [1:0] bcnt, ptr;
  logic [REG_W-1:0] rd_hold;
  logic tx_en, ack_drv, mack, cause_q;
  logic data_bit, ack_phase_start, ack_phase_end, lose_now;

  assign data_bit        = bitcnt < BITCNT_W'(8);
  assign ack_phase_start = scl_fall && bitcnt == BITCNT_W'(8);
  assign ack_phase_end   = scl_fall && bitcnt == BITCNT_W'(9);
  assign lose_now        = scl_rise && data_bit && tx_en && txreg[7] && !sda_s;
  assign sda_oe  = ack_drv | (tx_en & ~txreg[7]);
  assign rx_byte = shreg;
  assign reg_sel = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; txreg <= '1; bcnt <= '0;
      ptr <= 2'b00; rd_hold <= '0; tx_en <= 1'b0; ack_drv <= 1'b0;
      mack <= 1'b0; cause_q <= 1'b0; hs_mode <= 1'b0;
      rd_done <= 1'b0; wr_en <= 1'b0; wr_lsb <= 1'b0; wr_data <= '0;
      alert_clear <= 1'b0; gc_reset <= 1'b0; relatch <= 1'b0;
    end else begin
      rd_done <= 1'b0; wr_en <= 1'b0; alert_clear <= 1'b0;
      gc_reset <= 1'b0; relatch <= 1'b0;
      if (start_evt) begin
        st <= ST_ADDR; bitcnt <= '0; ack_drv <= 1'b0; tx_en <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE; ack_drv <= 1'b0; tx_en <= 1'b0; hs_mode <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (data_bit) shreg <= {shreg[6:0], sda_s};
          else          mack  <= !sda_s;
          if (lose_now) begin
            tx_en <= 1'b0; st <= ST_SKIP;
          end
          bitcnt <= bitcnt + 1'b1;
        end else if (ack_phase_start) begin
          tx_en <= 1'b0;
          unique case (st)
            ST_ADDR: begin
              bcnt <= '0;
              if (hit_w) begin
                ack_drv <= 1'b1; st <= ST_PTR;
              end else if (hit_r) begin
                ack_drv <= 1'b1; st <= ST_RDATA;
              end else if (hit_gc) begin
                ack_drv <= 1'b1; st <= ST_GCCMD;
              end else if (hit_ara && alert_pending) begin
                ack_drv <= 1'b1; cause_q <= alert_cause; st <= ST_ARA;
              end else begin
                if (hit_hs) hs_mode <= 1'b1;
                st <= ST_SKIP;
              end
            end
            ST_PTR: begin
              ack_drv <= 1'b1; ptr <= shreg[1:0]; bcnt <= '0; st <= ST_WDATA;
            end
            ST_WDATA: begin
              ack_drv <= 1'b1;
              if (keeps_byte(ptr, bcnt)) begin
                wr_en <= 1'b1; wr_lsb <= bcnt[0]; wr_data <= shreg;
              end
              if (bcnt != 2'd3) bcnt <= bcnt + 1'b1;
            end
            ST_GCCMD: begin
              ack_drv <= 1'b1;
              if (shreg == GC_LATCH || shreg == GC_RESET) relatch <= 1'b1;
              if (shreg == GC_RESET) begin
                gc_reset <= 1'b1; ptr <= 2'b00;
              end
              st <= ST_SKIP;
            end
            default: ;
          endcase
        end else if (ack_phase_end) begin
          ack_drv <= 1'b0;
          bitcnt  <= '0;
          if (st == ST_RDATA) begin
            if (bcnt == 2'd0) begin
              txreg <= rd_data[REG_W-1 -: 8]; rd_hold <= rd_data;
              tx_en <= 1'b1; bcnt <= 2'd1;
            end else begin
              if (bcnt == 2'd2) rd_done <= 1'b1;
              if (!mack) st <= ST_SKIP;
              else begin
                tx_en <= 1'b1;
                txreg <= (bcnt == 2'd1) ? rd_hold[7:0] : 8'hFF;
                if (bcnt != 2'd3) bcnt <= bcnt + 1'b1;
              end
            end
          end else if (st == ST_ARA) begin
            if (bcnt == 2'd0) begin
              txreg <= ara_reply(own_addr, cause_q); tx_en <= 1'b1; bcnt <= 2'd1;
            end else begin
              alert_clear <= 1'b1; st <= ST_SKIP;
            end
          end
        end else if (scl_fall && tx_en) begin
          txreg <= {txreg[6:0], 1'b1};
        end
      end
    end
  end

  // R13
  sda_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R8
  rd_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  // R12
  clear_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clear |-> alert_pending);
  // R10
  hs_exit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_mode) |-> $past(stop_evt));
  // R9
  gc_ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> reg_sel == 2'b00);
  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st == ST_IDLE && !sda_oe));
endmodule

// File: rtl/i2cp_slave.sv
module i2cp_slave import i2cp_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] PREFIX = 4'b1001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  output logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   rd_data,
  output logic               rd_done,
  output logic               wr_en,
  output logic               wr_lsb,
  output logic [7:0]         wr_data,
  input  logic               alert_pending,
  input  logic               alert_cause,
  output logic               alert_clear,
  output logic               gc_reset,
  output logic               hs_mode
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic relatch, hit_w, hit_r, hit_gc, hit_ara, hit_hs;
  logic [6:0] own_addr;
  logic [7:0] rx_byte;

  i2cp_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  i2cp_addr_dec #(.STRAP_W(STRAP_W), .PREFIX(PREFIX)) u_addr (
    .clk(clk), .rst_n(rst_n), .strap(strap), .relatch(relatch),
    .rx_byte(rx_byte), .own_addr(own_addr), .hit_w(hit_w), .hit_r(hit_r),
    .hit_gc(hit_gc), .hit_ara(hit_ara), .hit_hs(hit_hs));

  i2cp_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .own_addr(own_addr), .hit_w(hit_w), .hit_r(hit_r),
    .hit_gc(hit_gc), .hit_ara(hit_ara), .hit_hs(hit_hs), .rd_data(rd_data),
    .alert_pending(alert_pending), .alert_cause(alert_cause),
    .rx_byte(rx_byte), .sda_oe(sda_oe), .reg_sel(reg_sel), .rd_done(rd_done),
    .wr_en(wr_en), .wr_lsb(wr_lsb), .wr_data(wr_data),
    .alert_clear(alert_clear), .gc_reset(gc_reset), .relatch(relatch),
    .hs_mode(hs_mode));

  // R6
  no_temp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> reg_sel != 2'b00);
endmodule

// File: tb/i2cp_slave_test.sv
module i2cp_slave_test;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b010;
  logic alert_pending = 1'b0, alert_cause = 1'b0;
  logic sda_oe, rd_done, wr_en, wr_lsb, alert_clear, gc_reset, hs_mode;
  logic [1:0] reg_sel;
  logic [7:0] wr_data;
  logic [15:0] regs [4];
  logic [15:0] rd_data;
  wire sda_bus = m_sda & ~sda_oe;
  int tests = 0, fails = 0, cyc = 0;
  int n_rd_done = 0, n_clear = 0, n_gcr = 0, n_wr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign rd_data = regs[reg_sel];

  i2cp_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .reg_sel(reg_sel), .rd_data(rd_data), .rd_done(rd_done),
    .wr_en(wr_en), .wr_lsb(wr_lsb), .wr_data(wr_data),
    .alert_pending(alert_pending), .alert_cause(alert_cause),
    .alert_clear(alert_clear), .gc_reset(gc_reset), .hs_mode(hs_mode));

  always @(posedge clk) begin
    if (rd_done) n_rd_done++;
    if (alert_clear) n_clear++;
    if (gc_reset) n_gcr++;
    if (wr_en) begin
      n_wr++;
      if (wr_lsb) regs[reg_sel][7:0] <= wr_data;
      else        regs[reg_sel][15:8] <= wr_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  function automatic logic [6:0] dev(input logic [2:0] s);
    return {4'b1001, s};
  endfunction

  function automatic logic [15:0] expect_back(input logic [1:0] p, input logic [15:0] d);
    return (p == 2'b01) ? {d[15:8], 8'h00} : d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic q_wait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
    m_sda = 1'b0; q_wait(); m_scl = 1'b0; q_wait();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; q_wait(); m_scl = 1'b1; q_wait(); m_sda = 1'b1; q_wait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; q_wait(); m_scl = 1'b1; q_wait(); q_wait(); m_scl = 1'b0; q_wait();
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
    ack = !sda_bus; q_wait(); m_scl = 1'b0; q_wait();
  endtask

  task automatic rbyte(input logic mack, input logic [7:0] force_low, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = !force_low[i]; q_wait(); m_scl = 1'b1; q_wait();
      b[i] = sda_bus; q_wait(); m_scl = 1'b0; q_wait();
    end
    m_sda = !mack; q_wait(); m_scl = 1'b1; q_wait(); q_wait(); m_scl = 1'b0; q_wait();
    m_sda = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n,
                        input logic [15:0] d, output logic ack);
    logic k;
    do_start(); wbyte({a, 1'b0}, ack);
    wbyte(p, k);
    if (n > 0) wbyte(d[15:8], k);
    if (n > 1) wbyte(d[7:0], k);
    do_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a, output logic [15:0] v, output logic ack);
    logic [7:0] hi, lo;
    do_start(); wbyte({a, 1'b1}, ack);
    rbyte(1'b1, 8'h00, hi); rbyte(1'b0, 8'h00, lo);
    do_stop(); v = {hi, lo};
  endtask

  initial begin
    logic ack, k;
    logic [15:0] v;
    logic [7:0] b;
    logic [6:0] cur;
    int base, seed;
    seed = $urandom(32'd4242);
    regs[0] = 16'h1930; regs[1] = 16'h0000; regs[2] = 16'h4B00; regs[3] = 16'h5000;
    cur = dev(3'b010);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 reset pointer", reg_sel, 2'b00);
    chk("R13 reset sda released", sda_oe, 1'b0);
    chk("R10 reset hs_mode", hs_mode, 1'b0);

    // R2 / R5 / R6 configuration write, second byte discarded
    wr_txn(cur, 8'hFD, 2, 16'hA55A, ack);
    chk("R2 address ack", ack, 1'b1);
    chk("R4 pointer low bits", reg_sel, 2'b01);
    chk("R6 config keeps first byte", regs[1], 16'hA500);
    // R5 limit write both bytes, extra byte ignored
    base = n_wr;
    do_start(); wbyte({cur, 1'b0}, ack); wbyte(8'h02, k);
    wbyte(8'h12, k); wbyte(8'h34, k); wbyte(8'h99, k);
    chk("R5 extra byte acked", k, 1'b1);
    do_stop();
    chk("R5 two byte write", regs[2], 16'h1234);
    chk("R5 strobe count", n_wr - base, 2);
    // R6 temperature ignores data
    wr_txn(cur, 8'h00, 2, 16'hFFFF, ack);
    chk("R6 temp unchanged", regs[0], 16'h1930);
    // R4 / R7 / R8 pointer-only then read
    wr_txn(cur, 8'h03, 0, 16'h0, ack);
    base = n_rd_done;
    rd_txn(cur, v, ack);
    chk("R7 read high limit", v, 16'h5000);
    chk("R8 rd_done once", n_rd_done - base, 1);
    rd_txn(cur, v, ack);
    chk("R4 repeated read same ptr", v, 16'h5000);
    // R7 third byte and R8 early NACK
    do_start(); wbyte({cur, 1'b1}, ack);
    rbyte(1'b1, 8'h00, b); rbyte(1'b1, 8'h00, b); rbyte(1'b0, 8'h00, b);
    do_stop();
    chk("R7 third byte ones", b, 8'hFF);
    base = n_rd_done;
    do_start(); wbyte({cur, 1'b1}, ack); rbyte(1'b0, 8'h00, b); do_stop();
    chk("R7 msb first", b, 8'h50);
    chk("R8 no rd_done on early nack", n_rd_done - base, 0);
    // R2 wrong address
    wr_txn(7'h2A, 8'h02, 0, 16'h0, ack);
    chk("R2 foreign address nack", ack, 1'b0);
    chk("R2 pointer untouched", reg_sel, 2'b11);
    // R1 START in the middle of a data byte
    do_start(); wbyte({cur, 1'b0}, ack); wbyte(8'h02, k); send_bits(8'hF0, 4);
    do_start(); wbyte({cur, 1'b1}, ack); rbyte(1'b1, 8'h00, b); rbyte(1'b0, 8'h00, b);
    do_stop();
    chk("R1 restart mid byte acked", ack, 1'b1);
    chk("R1 aborted byte not written", regs[2], 16'h1234);
    // R3 / R9 strap relatch
    strap = 3'b101;
    wr_txn(cur, 8'h01, 0, 16'h0, ack);
    chk("R3 old address still owned", ack, 1'b1);
    wr_txn(dev(3'b101), 8'h01, 0, 16'h0, ack);
    chk("R3 new strap ignored", ack, 1'b0);
    do_start(); wbyte(8'h00, ack); wbyte(8'h04, k); do_stop();
    chk("R9 general call ack", ack, 1'b1);
    cur = dev(3'b101);
    wr_txn(cur, 8'h02, 0, 16'h0, ack);
    chk("R9 latch uses new strap", ack, 1'b1);
    base = n_gcr;
    do_start(); wbyte(8'h00, ack); wbyte(8'h06, k); do_stop();
    chk("R9 reset pulse", n_gcr - base, 1);
    chk("R9 pointer cleared", reg_sel, 2'b00);
    // R10 high-speed code
    do_start(); wbyte(8'h0B, ack);
    chk("R10 code not acked", ack, 1'b0);
    chk("R10 hs set", hs_mode, 1'b1);
    do_start(); wbyte({cur, 1'b0}, ack); wbyte(8'h02, k);
    chk("R10 hs kept over restart", hs_mode, 1'b1);
    do_stop();
    chk("R10 hs cleared by stop", hs_mode, 1'b0);
    // R11 / R12 alert response
    do_start(); wbyte(8'h19, ack); do_stop();
    chk("R11 no pending nack", ack, 1'b0);
    alert_pending = 1'b1; alert_cause = 1'b1;
    base = n_clear;
    do_start(); wbyte(8'h19, ack); rbyte(1'b0, 8'h00, b); do_stop();
    chk("R11 pending ack", ack, 1'b1);
    chk("R11 reply byte", b, {cur, 1'b1});
    chk("R12 clear on win", n_clear - base, 1);
    alert_cause = 1'b0;
    base = n_clear;
    do_start(); wbyte(8'h19, ack); rbyte(1'b0, 8'h80, b); do_stop();
    chk("R12 lost bus released", b, 8'h7F);
    chk("R12 no clear on loss", n_clear - base, 0);
    alert_pending = 1'b0;
    // R5 / R7 constrained random write/read-back
    for (int it = 0; it < 12; it++) begin
      logic [1:0] p;
      logic [15:0] d;
      p = 2'($urandom_range(1, 3));
      d = 16'($urandom);
      wr_txn(cur, {6'($urandom), p}, 2, d, ack);
      rd_txn(cur, v, ack);
      chk("R5 R7 random readback", v, expect_back(p, d));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule